// File: doc/BRIEF.md
# Dual LED Blink Controller

The block drives two LED outputs. Each LED has its own 8-bit control register on a small register bus (address, write enable, write data, read data). The two low bits of a register choose the LED's behaviour: dark, lit, an even blink with a one-second period, or a slow blink that is lit for a quarter of a two-second period. The upper six bits carry no state.

A prescaler divides the system clock down to a half-second tick. Every blink phase is a whole number of ticks, so a small clock-frequency parameter shrinks the whole timebase for simulation. When a write changes a channel's mode, that channel restarts its pattern at the first tick after the write, beginning with the lit phase. The channel number, the register depth and the clock frequency are all parameters.

Top module: `led_blink_ctrl`

## Requirements
- R1: After reset, both registers read 0x00 and both LED outputs are low.
- R2: Address 0 selects LED 0's register and address 1 selects LED 1's. The mode is in bits [1:0]: 00 dark, 01 even blink, 10 slow blink, 11 lit. A written mode reads back on the next cycle. Addresses 2 and 3 read 0x00, and writes to them change nothing.
- R3: Write data bits [7:2] are dropped, and read data bits [7:2] are always 0.
- R4: If a channel holds mode 00 in a cycle, its LED is low in the cycle after.
- R5: If a channel holds mode 11 in a cycle, its LED is high in the cycle after.
- R6: In mode 01 the LED repeats one tick lit and then one tick dark, starting from the restart.
- R7: In mode 10 the LED repeats one tick lit and then three ticks dark, starting from the restart.
- R8: The tick fires once every CLK_HZ/2 clock cycles, counted from reset release. So mode 01 has a period of CLK_HZ cycles and mode 10 a period of 2*CLK_HZ cycles.
- R9: A write that changes a channel's mode holds a blinking LED low until the first tick after the write. The lit phase then starts in the cycle after that tick. A write of the mode the channel already holds, whatever its reserved bits, leaves the pattern running without a restart.
- R10: The two channels are independent. Writing one channel's register never changes the other channel's mode, its phase or its LED.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | ADDR_W | Register address |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, combinational from reg_addr |
| led_out | output | NUM_LEDS | LED drive, active high, registered |

## Verification
Read data is combinational, so the bench samples it 1 ns after it drives the address at a falling edge. A written mode is visible at the first falling edge after the write edge. Each LED output is one register behind the channel's mode and phase state, so a steady mode shows one cycle after the write. A blink restart shows one cycle after the tick edge that clears the pending restart. A reference model in the bench advances at the same rising edges from the bus inputs alone and works out the tick count arithmetically. Every LED is compared against that model at every falling edge. Sweeps cover every pair of modes across every write offset within a tick period. The blink periods are also measured directly.

// File: rtl/led_blink_pkg.sv
`timescale 1ns/1ps
package led_blink_pkg;

  typedef enum logic [1:0] {
    MODE_DARK = 2'b00,
    MODE_EVEN = 2'b01,
    MODE_SLOW = 2'b10,
    MODE_LIT  = 2'b11
  } led_mode_e;

  localparam int MODE_W  = 2;
  localparam int PHASE_W = 2;

  // Lit/dark for a mode at a given tick phase (phase counts ticks since restart, mod 4).
  function automatic logic led_pattern(led_mode_e mode, logic [PHASE_W-1:0] phase);
    case (mode)
      MODE_DARK: return 1'b0;
      MODE_EVEN: return ~phase[0];
      MODE_SLOW: return (phase == '0);
      default:   return 1'b1;
    endcase
  endfunction

endpackage

// File: rtl/led_tick_gen.sv
`timescale 1ns/1ps
module led_tick_gen #(
  parameter int TICK_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CNT_W = (TICK_CYC > 1) ? $clog2(TICK_CYC) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TICK_CYC - 1);

  logic [CNT_W-1:0] cnt_q;

  assign tick = (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt_q <= '0;
    else if (tick) cnt_q <= '0;
    else           cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/led_mode_regs.sv
`timescale 1ns/1ps
module led_mode_regs
  import led_blink_pkg::*;
#(
  parameter int NUM_LEDS = 2,
  parameter int ADDR_W   = 2,
  parameter int DATA_W   = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [ADDR_W-1:0]             addr,
  input  logic                          we,
  input  logic [DATA_W-1:0]             wdata,
  output logic [DATA_W-1:0]             rdata,
  output led_mode_e [NUM_LEDS-1:0]      mode,
  output logic [NUM_LEDS-1:0]           restart
);
  localparam int RSVD_W = DATA_W - MODE_W;

  led_mode_e [NUM_LEDS-1:0] mode_q;
  led_mode_e                wmode;

  assign wmode = led_mode_e'(wdata[MODE_W-1:0]);
  assign mode  = mode_q;

  for (genvar i = 0; i < NUM_LEDS; i++) begin : g_reg
    logic hit;
    assign hit        = we && (addr == ADDR_W'(i));
    assign restart[i] = hit && (wmode != mode_q[i]);

    always_ff @(posedge clk) begin
      if (!rst_n)   mode_q[i] <= MODE_DARK;
      else if (hit) mode_q[i] <= wmode;
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM_LEDS; i++) begin
      if (addr == ADDR_W'(i)) rdata = {{RSVD_W{1'b0}}, mode_q[i]};
    end
  end
endmodule

// File: rtl/led_channel.sv
`timescale 1ns/1ps
module led_channel
  import led_blink_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick,
  input  led_mode_e mode,
  input  logic      restart,
  output logic      pending,
  output logic      led
);
  logic [PHASE_W-1:0] phase_q;
  logic               pend_q;
  logic               led_q;

  assign pending = pend_q;
  assign led     = led_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      phase_q <= '0;
      led_q   <= 1'b0;
    end else begin
      if (restart)   pend_q <= 1'b1;
      else if (tick) pend_q <= 1'b0;

      if (tick) phase_q <= pend_q ? '0 : phase_q + 1'b1;

      led_q <= pend_q ? (mode == MODE_LIT) : led_pattern(mode, phase_q);
    end
  end
endmodule

// File: rtl/led_blink_ctrl.sv
`timescale 1ns/1ps
module led_blink_ctrl
  import led_blink_pkg::*;
#(
  parameter int CLK_HZ   = 50_000_000,
  parameter int NUM_LEDS = 2,
  parameter int ADDR_W   = 2,
  parameter int DATA_W   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic                reg_we,
  input  logic [DATA_W-1:0]   reg_wdata,
  output logic [DATA_W-1:0]   reg_rdata,
  output logic [NUM_LEDS-1:0] led_out
);
  localparam int TICK_CYC = CLK_HZ / 2;

  logic                     tick_w;
  led_mode_e [NUM_LEDS-1:0] mode_w;
  logic [NUM_LEDS-1:0]      restart_w;
  logic [NUM_LEDS-1:0]      pend_w;

  led_tick_gen #(.TICK_CYC(TICK_CYC)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick(tick_w)
  );

  led_mode_regs #(.NUM_LEDS(NUM_LEDS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(reg_addr), .we(reg_we), .wdata(reg_wdata),
    .rdata(reg_rdata), .mode(mode_w), .restart(restart_w)
  );

  for (genvar i = 0; i < NUM_LEDS; i++) begin : g_ch
    led_channel u_ch (
      .clk(clk), .rst_n(rst_n), .tick(tick_w), .mode(mode_w[i]),
      .restart(restart_w[i]), .pending(pend_w[i]), .led(led_out[i])
    );
  end
endmodule

// File: rtl/led_blink_ctrl_sva.sv
`timescale 1ns/1ps
module led_blink_ctrl_sva
  import led_blink_pkg::*;
#(
  parameter int CLK_HZ   = 50_000_000,
  parameter int NUM_LEDS = 2,
  parameter int ADDR_W   = 2,
  parameter int DATA_W   = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [ADDR_W-1:0]        reg_addr,
  input logic                     reg_we,
  input logic [DATA_W-1:0]        reg_wdata,
  input logic [DATA_W-1:0]        reg_rdata,
  input logic                     tick,
  input led_mode_e [NUM_LEDS-1:0] mode,
  input logic [NUM_LEDS-1:0]      pend,
  input logic [NUM_LEDS-1:0]      led
);
  localparam int TICK_CYC = CLK_HZ / 2;
  localparam int GAP_W    = $clog2(TICK_CYC + 1);

  logic [GAP_W-1:0] gap_q;
  always_ff @(posedge clk) begin
    if (!rst_n || tick) gap_q <= '0;
    else                gap_q <= gap_q + 1'b1;
  end

  // R8: ticks are spaced exactly TICK_CYC cycles apart, counted by an independent counter
  a_r8_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> (gap_q == GAP_W'(TICK_CYC - 1)));

  // R3: reserved read bits stay zero
  a_r3_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[DATA_W-1:MODE_W] == '0);

  for (genvar i = 0; i < NUM_LEDS; i++) begin : g_led
    // R2: a write to this channel's address lands in its mode
    a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == ADDR_W'(i)) |=> (mode[i] == $past(reg_wdata[MODE_W-1:0])));
    // R4: dark mode gives a low LED one cycle later
    a_r4_dark: assert property (@(posedge clk) disable iff (!rst_n)
      (mode[i] == MODE_DARK) |=> !led[i]);
    // R5: lit mode gives a high LED one cycle later
    a_r5_lit: assert property (@(posedge clk) disable iff (!rst_n)
      (mode[i] == MODE_LIT) |=> led[i]);
    // R9: a blink awaiting its restart tick stays dark
    a_r9_pending_dark: assert property (@(posedge clk) disable iff (!rst_n)
      (pend[i] && (mode[i] == MODE_EVEN || mode[i] == MODE_SLOW)) |=> !led[i]);
  end
endmodule

bind led_blink_ctrl led_blink_ctrl_sva #(
  .CLK_HZ(CLK_HZ), .NUM_LEDS(NUM_LEDS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_sva (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tick(tick_w),
  .mode(mode_w), .pend(pend_w), .led(led_out)
);

// File: tb/led_blink_ctrl_tb.sv
`timescale 1ns/1ps
module led_blink_ctrl_tb;
  localparam int CLK_HZ = 16;
  localparam int T      = CLK_HZ / 2;
  localparam int NL     = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] reg_addr = '0;
  logic       reg_we = 1'b0;
  logic [7:0] reg_wdata = '0;
  wire  [7:0] reg_rdata;
  wire  [NL-1:0] led_out;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  led_blink_ctrl #(.CLK_HZ(CLK_HZ), .NUM_LEDS(NL), .ADDR_W(2), .DATA_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .led_out(led_out)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Reference: tick index from reset release, pattern from ticks since restart
  int         rcyc;
  logic [1:0] rmode [NL];
  logic       rpend [NL];
  int         rk    [NL];
  logic [NL-1:0] exp_led;
  string      exp_tag [NL];
  wire        ref_tick = (rcyc == T - 1);

  function automatic logic want_on(logic [1:0] m, int k);
    case (m)
      2'd0:    return 1'b0;
      2'd1:    return (k % 2) == 0;
      2'd2:    return (k % 4) == 0;
      default: return 1'b1;
    endcase
  endfunction

  function automatic string tag_for(logic [1:0] m, logic p);
    if (p && (m == 2'd1 || m == 2'd2)) return "R9 restart";
    case (m)
      2'd0:    return "R4 dark";
      2'd1:    return "R6 even blink";
      2'd2:    return "R7 slow blink";
      default: return "R5 lit";
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      rcyc <= 0;
      for (int i = 0; i < NL; i++) begin
        rmode[i] <= 2'd0; rpend[i] <= 1'b0; rk[i] <= 0;
        exp_led[i] <= 1'b0; exp_tag[i] <= "R1 reset";
      end
    end else begin
      rcyc <= ref_tick ? 0 : rcyc + 1;
      for (int i = 0; i < NL; i++) begin
        exp_led[i] <= rpend[i] ? (rmode[i] == 2'd3) : want_on(rmode[i], rk[i]);
        exp_tag[i] <= tag_for(rmode[i], rpend[i]);
        if (reg_we && reg_addr == 2'(i) && reg_wdata[1:0] != rmode[i]) begin
          rmode[i] <= reg_wdata[1:0];
          rpend[i] <= 1'b1;
        end else if (ref_tick) begin
          rpend[i] <= 1'b0;
        end
        if (ref_tick) rk[i] <= rpend[i] ? 0 : (rk[i] + 1) % 4;
      end
    end
  end

  // Every-cycle comparison of each LED (R10: the other channel's writes must not disturb it)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      for (int i = 0; i < NL; i++)
        chk(led_out[i] == exp_led[i], {exp_tag[i], " R10 led", (i == 0) ? "0" : "1"},
            int'(led_out[i]), int'(exp_led[i]));
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    reg_addr = a;
    #1;
    chk(reg_rdata == exp, tag, int'(reg_rdata), int'(exp));
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Cycles between two rising edges, and the lit width, of one LED
  task automatic measure(input int ch, output int period, output int width);
    int c;
    c = 0;
    while (!(led_out[ch] == 1'b0)) @(posedge clk);
    while (led_out[ch] == 1'b0) @(posedge clk);
    width = 0;
    while (led_out[ch] == 1'b1) begin @(posedge clk); width++; c++; end
    while (led_out[ch] == 1'b0) begin @(posedge clk); c++; end
    period = c;
  endtask

  initial begin
    int per, wid;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(led_out == '0, "R1 leds after reset", int'(led_out), 0);
    rst_n = 1'b1;
    rd(2'd0, 8'h00, "R1 reg0 after reset");
    rd(2'd1, 8'h00, "R1 reg1 after reset");

    // R2/R3 decode and reserved bits
    wr(2'd0, 8'hFD);
    rd(2'd0, 8'h01, "R3 reg0 reserved dropped");
    wr(2'd1, 8'hAE);
    rd(2'd1, 8'h02, "R2 reg1 readback");
    wr(2'd2, 8'hFF);
    wr(2'd3, 8'hFF);
    rd(2'd2, 8'h00, "R2 addr2 reads zero");
    rd(2'd3, 8'h00, "R2 addr3 reads zero");
    rd(2'd0, 8'h01, "R2 reg0 untouched by addr2/3 writes");
    rd(2'd1, 8'h02, "R2 reg1 untouched by addr2/3 writes");

    // R8 periods
    measure(0, per, wid);
    chk(per == 2 * T, "R8 even period", per, 2 * T);
    chk(wid == T, "R6 even lit width", wid, T);
    measure(1, per, wid);
    chk(per == 4 * T, "R8 slow period", per, 4 * T);
    chk(wid == T, "R7 slow lit width", wid, T);

    // R9 same-mode rewrite does not restart; pattern continuity checked each cycle
    idle(3);
    wr(2'd0, 8'h01);
    wr(2'd0, 8'h7D);
    idle(2 * T);
    rd(2'd0, 8'h01, "R9 same-mode rewrite readback");

    // Sweep every mode pair across every write offset inside a tick
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++)
        for (int off = 0; off < T; off++) begin
          wr(2'd0, 8'(a) | 8'hC0);
          idle(off);
          wr(2'd1, 8'(b) | 8'h14);
          idle(4 * T + 3);
        end

    // Back-to-back changing writes
    wr(2'd0, 8'h02);
    wr(2'd0, 8'h01);
    wr(2'd1, 8'h03);
    wr(2'd1, 8'h02);
    idle(6 * T);
    rd(2'd0, 8'h01, "R2 reg0 final");
    rd(2'd1, 8'h02, "R10 reg1 final");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule